// File: doc/BRIEF.md
# Packed Colour Lookup RAM

This block holds a 256-colour lookup table for a display pipeline. Software fills it through a simple word-wide register bus. Each 32-bit word holds two 16-bit colour entries. Each entry packs three 5-bit channels and one intensity flag. A pixel engine presents an 8-bit colour index. One cycle later it gets back a 24-bit colour with 8 bits per channel. Each 5-bit channel is widened by appending three zero bits, and the intensity flag is dropped.

The bus takes word addresses. The table occupies word addresses 0x080 to 0x0FF, which are byte offsets 0x200 to 0x3FC of the display register space. Reads return the word exactly as software wrote it, including the intensity flags. A per-request swap input lets the pixel side exchange the red and blue channels. This serves panels wired in blue-first order.

Top module: `palram_top`

## Requirements
- R1: After reset, every stored word is zero, `pix_valid` is 0 and `bus_rdata` is 0, so a lookup of any index returns colour 0.
- R2: Only word addresses 0x080 to 0x0FF (byte offsets 0x200 to 0x3FC) reach the table, with stored word n = address − 0x080. A write outside this window changes nothing, and a read outside it returns 0.
- R3: A bus read (`bus_en`=1, `bus_we`=0) of a table word places the raw stored word on `bus_rdata` one cycle later. `bus_rdata` holds its value in every cycle with no read.
- R4: Index 2n is taken from bits [15:0] of word n, and index 2n+1 from bits [31:16].
- R5: Within a 16-bit entry, red is [4:0], green is [9:5] and blue is [14:10]. The output `pix_rgb` is {red, green, blue}, with red at [23:16] and blue at [7:0].
- R6: Each channel is widened as {c5, 3'b000}, so bits [2:0] of every output channel are zero.
- R7: The intensity flag (bit 15 of an entry) has no effect on the lookup result.
- R8: When `bgr_swap` is 1 in the request cycle, the red and blue channels change places: `pix_rgb` becomes {blue, green, red}.
- R9: `pix_valid` is 1 exactly in the cycle after a cycle with `pix_req`=1, and that cycle's `pix_rgb` is the result for that request. With no request, `pix_rgb` holds its previous value.
- R10: A write is seen by lookups issued in later cycles. A lookup issued in the same cycle as a write to its word returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read, qualified by bus_en |
| bus_addr | input | 10 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pix_req | input | 1 | Lookup request |
| pix_idx | input | 8 | Colour index to look up |
| bgr_swap | input | 1 | Exchange red and blue for this request |
| pix_valid | output | 1 | Lookup result valid |
| pix_rgb | output | 24 | Widened colour {R,G,B} (or {B,G,R} when swapped) |

## Verification
The assertions assume that every control input (`bus_en`, `bus_we`, `pix_req`) is a known 0 or 1 at each rising edge after reset. They also assume that one bus operation at most is requested per cycle, with the direction chosen by `bus_we` alone. The stimulus changes inputs only on falling edges and returns each strobe to 0 as soon as its cycle ends, so no edge sees a half-changed input. Lookups and writes to the same word are overlapped in only one deliberate cycle, and that cycle checks the ordering rule.

// File: rtl/palram_pkg.sv
package palram_pkg;
    localparam int OUT_CH_W = 8;

    typedef logic [OUT_CH_W-1:0] chan_t;

    typedef struct packed {
        chan_t r;
        chan_t g;
        chan_t b;
    } rgb_t;

    typedef struct packed {
        logic valid;
        rgb_t rgb;
    } look_t;
endpackage

// File: rtl/palram_decode.sv
module palram_decode #(
    parameter int WADDR_W   = 10,
    parameter int WIDX_W    = 7,
    parameter int BASE_BYTE = 32'h200
) (
    input  logic [WADDR_W-1:0] addr,
    output logic               hit,
    output logic [WIDX_W-1:0]  widx
);
    localparam int TAG_W = WADDR_W - WIDX_W;
    localparam int TAG_I = BASE_BYTE >> (WIDX_W + 2);

    always_comb begin
        hit  = (32'(addr[WADDR_W-1:WIDX_W]) == TAG_I);
        widx = addr[WIDX_W-1:0];
    end
endmodule

// File: rtl/palram_store.sv
module palram_store #(
    parameter int WIDX_W = 7,
    parameter int CH_W   = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic                  hit,
    input  logic [WIDX_W-1:0]     widx,
    input  logic [2*(3*CH_W+1)-1:0] wdata,
    output logic [2*(3*CH_W+1)-1:0] rdata,
    input  logic [WIDX_W:0]       lk_idx,
    output logic [3*CH_W-1:0]     lk_color
);
    localparam int WORDS   = 2 ** WIDX_W;
    localparam int ENTRY_W = 3 * CH_W + 1;
    localparam int WORD_W  = 2 * ENTRY_W;
    localparam int COL_W   = 3 * CH_W;

    logic [WORD_W-1:0] mem_d [WORDS];
    logic [WORD_W-1:0] mem_q [WORDS];
    logic [WORD_W-1:0] rdata_d, rdata_q;
    logic [WORD_W-1:0] lk_word;

    always_comb begin
        mem_d   = mem_q;
        rdata_d = rdata_q;
        if (wr_en && hit) begin
            mem_d[widx] = wdata;
        end
        if (rd_en) begin
            rdata_d = hit ? mem_q[widx] : '0;
        end
        lk_word  = mem_q[lk_idx[WIDX_W:1]];
        lk_color = lk_idx[0] ? lk_word[ENTRY_W +: COL_W] : lk_word[0 +: COL_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '0;
            end
            rdata_q <= '0;
        end else begin
            mem_q   <= mem_d;
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    // R2: a read outside the window yields zero on the next cycle
    a_r2_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> (rdata_q == '0));

    // R3: read data holds when no read is issued
    a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/palram_expand.sv
module palram_expand
    import palram_pkg::*;
#(
    parameter int CH_W = 5
) (
    input  logic [3*CH_W-1:0] color,
    input  logic              swap,
    output rgb_t              rgb
);
    localparam int PAD_W = OUT_CH_W - CH_W;

    chan_t red, grn, blu;

    always_comb begin
        red = {color[0 +: CH_W],        {PAD_W{1'b0}}};
        grn = {color[CH_W +: CH_W],     {PAD_W{1'b0}}};
        blu = {color[2*CH_W +: CH_W],   {PAD_W{1'b0}}};
        rgb.g = grn;
        if (swap) begin
            rgb.r = blu;
            rgb.b = red;
        end else begin
            rgb.r = red;
            rgb.b = blu;
        end
    end
endmodule

// File: rtl/palram_top.sv
module palram_top
    import palram_pkg::*;
#(
    parameter int IDX_W     = 8,
    parameter int CH_W      = 5,
    parameter int WADDR_W   = 10,
    parameter int BASE_BYTE = 32'h200
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_en,
    input  logic                          bus_we,
    input  logic [WADDR_W-1:0]            bus_addr,
    input  logic [2*(3*CH_W+1)-1:0]       bus_wdata,
    output logic [2*(3*CH_W+1)-1:0]       bus_rdata,
    input  logic                          pix_req,
    input  logic [IDX_W-1:0]              pix_idx,
    input  logic                          bgr_swap,
    output logic                          pix_valid,
    output logic [3*OUT_CH_W-1:0]         pix_rgb
);
    localparam int WIDX_W = IDX_W - 1;
    localparam int PAD_W  = OUT_CH_W - CH_W;

    logic              hit;
    logic [WIDX_W-1:0] widx;
    logic [3*CH_W-1:0] lk_color;
    rgb_t              lk_rgb;
    look_t             look_d, look_q;

    palram_decode #(
        .WADDR_W  (WADDR_W),
        .WIDX_W   (WIDX_W),
        .BASE_BYTE(BASE_BYTE)
    ) u_decode (
        .addr(bus_addr),
        .hit (hit),
        .widx(widx)
    );

    palram_store #(
        .WIDX_W(WIDX_W),
        .CH_W  (CH_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_en && bus_we),
        .rd_en   (bus_en && !bus_we),
        .hit     (hit),
        .widx    (widx),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .lk_idx  (pix_idx),
        .lk_color(lk_color)
    );

    palram_expand #(
        .CH_W(CH_W)
    ) u_expand (
        .color(lk_color),
        .swap (bgr_swap),
        .rgb  (lk_rgb)
    );

    always_comb begin
        look_d       = look_q;
        look_d.valid = pix_req;
        if (pix_req) begin
            look_d.rgb = lk_rgb;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            look_q <= '0;
        end else begin
            look_q <= look_d;
        end
    end

    assign pix_valid = look_q.valid;
    assign pix_rgb   = look_q.rgb;

    // R9: valid rises one cycle after a request
    a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |=> pix_valid);

    // R9: valid stays low when no request preceded it
    a_r9_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_req |=> !pix_valid);

    // R6: padding bits of each output channel are zero
    a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_rgb[0 +: PAD_W] == '0 &&
                       pix_rgb[OUT_CH_W +: PAD_W] == '0 &&
                       pix_rgb[2*OUT_CH_W +: PAD_W] == '0));
endmodule

// File: tb/tb_palram_top.sv
module tb_palram_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pix_req = 1'b0;
    logic [7:0]  pix_idx = '0;
    logic        bgr_swap = 1'b0;
    logic        pix_valid;
    logic [23:0] pix_rgb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] model [128];

    palram_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pix_req  (pix_req),
        .pix_idx  (pix_idx),
        .bgr_swap (bgr_swap),
        .pix_valid(pix_valid),
        .pix_rgb  (pix_rgb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // write vectors: {word address, data}
    localparam logic [41:0] WVEC [5] = '{
        {10'h080, 32'h801F_7C00},
        {10'h081, 32'h03E0_5294},
        {10'h0C3, 32'hFFFF_1234},
        {10'h0FF, 32'hA5A5_5A5A},
        {10'h0A0, 32'h0001_8000}
    };
    // lookup vectors: {swap, index}
    localparam logic [8:0] LVEC [10] = '{
        {1'b0, 8'h00}, {1'b0, 8'h01}, {1'b1, 8'h02}, {1'b0, 8'h03},
        {1'b1, 8'h86}, {1'b0, 8'h87}, {1'b0, 8'hFE}, {1'b1, 8'hFF},
        {1'b0, 8'h40}, {1'b1, 8'h41}
    };

    function automatic logic [23:0] colour(input logic [31:0] w, input logic [7:0] i,
                                           input logic sw);
        logic [15:0] e;
        logic [7:0]  r, g, b;
        e = i[0] ? w[31:16] : w[15:0];
        r = {e[4:0], 3'b000};
        g = {e[9:5], 3'b000};
        b = {e[14:10], 3'b000};
        return sw ? {b, g, r} : {r, g, b};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bwrite(input logic [9:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        if (a >= 10'h080 && a <= 10'h0FF) model[a[6:0]] = d;
    endtask

    task automatic bread(input logic [9:0] a);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic look(input logic [7:0] i, input logic sw);
        pix_req = 1'b1; pix_idx = i; bgr_swap = sw;
        @(negedge clk);
        pix_req = 1'b0; bgr_swap = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 128; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 valid", {31'b0, pix_valid}, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        look(8'h05, 1'b0);
        chk("R1 lookup", {8'h0, pix_rgb}, 32'h0);
        bread(10'h0C0);
        chk("R1 word", bus_rdata, 32'h0);

        // fill from table, read back raw (R3, R7 flags kept)
        for (int k = 0; k < 5; k++) bwrite(WVEC[k][41:32], WVEC[k][31:0]);
        for (int k = 0; k < 5; k++) begin
            bread(WVEC[k][41:32]);
            chk("R3 raw readback", bus_rdata, WVEC[k][31:0]);
        end

        // lookup table walk: R4 R5 R6 R7 R8 R9
        for (int k = 0; k < 10; k++) begin
            look(LVEC[k][7:0], LVEC[k][8]);
            chk("R9 valid", {31'b0, pix_valid}, 32'h1);
            chk("R4 R5 R8 colour", {8'h0, pix_rgb},
                {8'h0, colour(model[LVEC[k][7:1]], LVEC[k][7:0], LVEC[k][8])});
        end

        // R9: no request -> valid low, colour held
        @(negedge clk);
        chk("R9 valid low", {31'b0, pix_valid}, 32'h0);
        chk("R9 colour held", {8'h0, pix_rgb},
            {8'h0, colour(model[8'h41 >> 1], 8'h41, 1'b1)});

        // R3: read data held with no read
        bread(10'h081);
        @(negedge clk);
        @(negedge clk);
        chk("R3 hold", bus_rdata, 32'h03E0_5294);

        // R2: out-of-window accesses
        bwrite(10'h07F, 32'hDEAD_BEEF);
        bwrite(10'h100, 32'hCAFE_F00D);
        bread(10'h07F);
        chk("R2 read below", bus_rdata, 32'h0);
        bread(10'h081);
        bread(10'h100);
        chk("R2 read above", bus_rdata, 32'h0);
        bread(10'h080);
        chk("R2 first word untouched", bus_rdata, 32'h801F_7C00);
        bread(10'h0FF);
        chk("R2 last word untouched", bus_rdata, 32'hA5A5_5A5A);
        look(8'h00, 1'b0);
        chk("R2 lookup untouched", {8'h0, pix_rgb}, {8'h0, 24'h0000F8});

        // R7: intensity bit does not matter
        bwrite(10'h090, 32'h7FFF_FFFF);
        look(8'h20, 1'b0);
        chk("R7 flag set", {8'h0, pix_rgb}, {8'h0, 24'hF8F8F8});
        look(8'h21, 1'b0);
        chk("R7 flag clear", {8'h0, pix_rgb}, {8'h0, 24'hF8F8F8});

        // R5 R6: single channels
        bwrite(10'h091, 32'h03E0_0001);
        look(8'h22, 1'b0);
        chk("R5 R6 red lsb", {8'h0, pix_rgb}, {8'h0, 24'h080000});
        look(8'h23, 1'b1);
        chk("R5 R8 green swap", {8'h0, pix_rgb}, {8'h0, 24'h00F800});

        // R10: same-cycle write and lookup sees old, next sees new
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 10'h091; bus_wdata = 32'h0000_7C00;
        pix_req = 1'b1; pix_idx = 8'h22; bgr_swap = 1'b0;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        chk("R10 old value", {8'h0, pix_rgb}, {8'h0, 24'h080000});
        @(negedge clk);
        pix_req = 1'b0;
        chk("R10 new value", {8'h0, pix_rgb}, {8'h0, 24'h0000F8});

        // R1: reset clears stored words
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 valid after reset", {31'b0, pix_valid}, 32'h0);
        bread(10'h0FF);
        chk("R1 cleared word", bus_rdata, 32'h0);

        finish_run();
    end
endmodule